// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer and Data Enable

This block sits between a processor that time-shares one byte of pins for the low address and the data, and a conventional system bus with separate address and data. A strobe input, high at the start of every bus cycle, marks the moments when the shared byte carries the address. While the strobe is high, the block passes the shared byte and the high address byte straight through to a 16-bit address output. It also samples them, together with the three cycle-status lines, on each rising clock edge. When the strobe drops, the last sampled values are held on the outputs until the next strobe pulse. Any data that then appears on the shared byte has no effect on them.

The block also produces an active-low enable for the external data transceivers and a direction signal for them. During a read-type cycle (status S1 high) the enable follows the read strobe once the address strobe is low. During a write-type cycle (S1 low) the enable is asserted for the whole data portion of the cycle, from the fall of the address strobe onward. The write data therefore reaches the bus without a race against the write strobe. The clock is a free-running clock at twice the bus rate, so the whole block stays synchronous.

Top module: `mux_bus_demux`

## Requirements
- R1: While `ale` is high, `addr_out[7:0]` equals `ad_in` and `addr_out[15:8]` equals `hi_in` in the same cycle.
- R2: While `ale` is low, `addr_out` holds the value that `{hi_in, ad_in}` had at the last rising clock edge where `ale` was high, whatever `ad_in` and `hi_in` do meanwhile.
- R3: `stat_s1`, `stat_s0` and `stat_iom_n` follow `s1_in`, `s0_in` and `iom_n_in` while `ale` is high. While `ale` is low they hold the values sampled at the last rising edge with `ale` high.
- R4: Whenever `ale` is high, `den_n` is 1.
- R5: With `ale` low and the held S1 equal to 1 (read-type cycle), `den_n` equals `rd_n`.
- R6: With `ale` low and the held S1 equal to 0 (write-type cycle), `den_n` is 0.
- R7: `dir_to_cpu` is 1 exactly when `rd_n` is 0 and `wr_n` is 1; otherwise it is 0.
- R8: An active-low reset clears the held address and held status to zero, so after reset with `ale` low, `addr_out` is 0 and all three status outputs are 0.
- R9: Changes of `s1_in` while `ale` is low have no effect on `den_n` or `stat_s1`. Only the S1 value held from the address phase selects the enable equation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock at twice the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | 8 | Shared low-address / data byte |
| hi_in | input | 8 | High address byte |
| ale | input | 1 | Address strobe, high while the shared byte holds the address |
| s0_in | input | 1 | Cycle status bit 0 |
| s1_in | input | 1 | Cycle status bit 1 (1 = read-type) |
| iom_n_in | input | 1 | I/O-or-memory status (low = memory) |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr_out | output | 16 | Demultiplexed address {high, low} |
| stat_s0 | output | 1 | Held status bit 0 |
| stat_s1 | output | 1 | Held status bit 1 |
| stat_iom_n | output | 1 | Held I/O-or-memory status |
| dir_to_cpu | output | 1 | Transceiver direction, 1 = toward the processor |
| den_n | output | 1 | Active-low data transceiver enable |

## Verification
The bench keeps the strobe high for two clocks in some cycles while the shared byte changes. A design that captured on the first edge instead of the last would hold a stale address. After the strobe falls, the bench drives fresh data on the shared byte and the high byte every clock. An address output that stayed transparent would then follow the data. Between the read and write cycles it flips `s1_in` during the data phase. A design that used the live status line instead of the held one would toggle the enable in the middle of a cycle. The bench also checks that the enable is low at once in a write cycle, before the write strobe, and that it stays off during the strobe in both cycle types.

// File: rtl/mux_bus_demux.sv
module mux_bus_demux #(
  parameter int LO_W = 8,
  parameter int HI_W = 8,
  localparam int AW = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LO_W-1:0] ad_in,
  input  logic [HI_W-1:0] hi_in,
  input  logic            ale,
  input  logic            s0_in,
  input  logic            s1_in,
  input  logic            iom_n_in,
  input  logic            rd_n,
  input  logic            wr_n,
  output logic [AW-1:0]   addr_out,
  output logic            stat_s0,
  output logic            stat_s1,
  output logic            stat_iom_n,
  output logic            dir_to_cpu,
  output logic            den_n
);

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic [2:0]      st_q;
  logic [2:0]      st_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      st_q <= '0;
    end else if (ale) begin
      lo_q <= ad_in;
      hi_q <= hi_in;
      st_q <= {s1_in, s0_in, iom_n_in};
    end
  end

  assign addr_out   = ale ? {hi_in, ad_in} : {hi_q, lo_q};
  assign st_now     = ale ? {s1_in, s0_in, iom_n_in} : st_q;
  assign stat_s1    = st_now[2];
  assign stat_s0    = st_now[1];
  assign stat_iom_n = st_now[0];

  assign den_n      = ale | (st_now[2] & rd_n);
  assign dir_to_cpu = ~rd_n & wr_n;

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ale) && $past(rst_n)) |-> addr_out == $past({hi_in, ad_in}));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && !$past(ale) && $past(rst_n)) |-> $stable(addr_out));

  assert_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ale) && $past(rst_n)) |->
      {stat_s1, stat_s0, stat_iom_n} == $past({s1_in, s0_in, iom_n_in}));

  assert_write_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ale) && $past(rst_n) && !$past(s1_in)) |-> !den_n);

  assert_read_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ale) && $past(rst_n) && $past(s1_in)) |-> den_n == rd_n);

endmodule

// File: tb/test_mux_bus_demux.sv
module test_mux_bus_demux;
  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] ad_in = 0, hi_in = 0;
  logic ale = 0, s0_in = 0, s1_in = 0, iom_n_in = 0, rd_n = 1, wr_n = 1;
  logic [15:0] addr_out;
  logic stat_s0, stat_s1, stat_iom_n, dir_to_cpu, den_n;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_addr = 0;
  logic [2:0]  m_st = 0;

  always #5 clk = ~clk;

  mux_bus_demux i_mux_bus_demux (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .hi_in(hi_in), .ale(ale),
    .s0_in(s0_in), .s1_in(s1_in), .iom_n_in(iom_n_in), .rd_n(rd_n), .wr_n(wr_n),
    .addr_out(addr_out), .stat_s0(stat_s0), .stat_s1(stat_s1),
    .stat_iom_n(stat_iom_n), .dir_to_cpu(dir_to_cpu), .den_n(den_n));

  // reference model: remembers what was on the bus at the last edge with the strobe high
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr <= 0;
      m_st <= 0;
    end else if (ale) begin
      m_addr <= {hi_in, ad_in};
      m_st <= {s1_in, s0_in, iom_n_in};
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [15:0] ea;
      logic [2:0]  es;
      logic        ed;
      ea = ale ? {hi_in, ad_in} : m_addr;
      es = ale ? {s1_in, s0_in, iom_n_in} : m_st;
      if (ale) ed = 1;
      else if (es[2]) ed = rd_n;
      else ed = 0;
      chk(ale ? "R1 addr" : "R2 addr", addr_out, ea);
      chk(ale ? "R3 status follow" : "R3/R9 status hold",
          {13'd0, stat_s1, stat_s0, stat_iom_n}, {13'd0, es});
      chk(ale ? "R4 den" : (es[2] ? "R5/R9 den read" : "R6/R9 den write"),
          {15'd0, den_n}, {15'd0, ed});
      chk("R7 dir", {15'd0, dir_to_cpu}, {15'd0, (!rd_n && wr_n)});
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic bus_cycle(input logic [15:0] a, input logic [2:0] st,
                           input bit rd, input int ale_len, input int data_len,
                           input bit flip_s1);
    ale = 1; hi_in = a[15:8]; ad_in = a[7:0];
    {s1_in, s0_in, iom_n_in} = st;
    for (int i = 0; i < ale_len; i++) begin
      step();
      if (i + 1 < ale_len) ad_in = ad_in + 8'h11;
    end
    ale = 0;
    for (int i = 0; i < data_len; i++) begin
      ad_in = 8'hA0 ^ 8'(i * 37);
      hi_in = 8'h5C + 8'(i);
      if (flip_s1) s1_in = ~s1_in;
      if (i > 0 && i + 1 < data_len) begin
        if (rd) rd_n = 0; else wr_n = 0;
      end else begin
        rd_n = 1; wr_n = 1;
      end
      step();
    end
    rd_n = 1; wr_n = 1;
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          errors++; checks++;
          $display("FAIL watchdog expired");
          done = 1;
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none
    repeat (3) step();
    rst_n = 1;
    #1;
    // R8: reset state with strobe low
    chk("R8 reset addr", addr_out, 16'h0000);
    chk("R8 reset status", {13'd0, stat_s1, stat_s0, stat_iom_n}, 16'h0000);
    step();
    bus_cycle(16'h12F0, 3'b110, 1, 1, 5, 0);  // memory read
    bus_cycle(16'h8034, 3'b010, 0, 1, 5, 0);  // memory write
    bus_cycle(16'hBEEF, 3'b111, 1, 2, 6, 0);  // I/O read, long strobe
    bus_cycle(16'h0077, 3'b001, 0, 2, 6, 0);  // I/O write, long strobe
    bus_cycle(16'h4321, 3'b110, 1, 1, 6, 1);  // R9: read with live S1 toggling
    bus_cycle(16'hC3A5, 3'b010, 0, 1, 6, 1);  // R9: write with live S1 toggling
    for (int k = 0; k < 20; k++)
      bus_cycle(16'(k * 4099 + 7), {k[0], k[1], k[2]}, k[0], 1 + (k % 2), 4 + (k % 3), k[1]);
    // R9 explicit: hold a write cycle, move s1_in, enable must stay on
    bus_cycle(16'h2222, 3'b010, 0, 1, 2, 0);
    ale = 0; s1_in = 1; rd_n = 1;
    #1;
    chk("R9 den ignores live s1", {15'd0, den_n}, 16'h0000);
    chk("R9 stat_s1 held", {15'd0, stat_s1}, 16'h0000);
    chk("R2 addr held", addr_out, 16'h2222);
    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule